// File: doc/BRIEF.md
# Flash Command Sequencer with Erase Suspend

The block sits between a CPU and a behavioural flash array. It runs byte program, page program, sector erase and chip erase, each for a fixed number of clock cycles set by a parameter. While an operation is loading or running, it raises a busy flag, makes every array read return 8'hFF, and keeps CPU writes away from the array. A sector erase can be paused. While it is paused, reads return real array contents and one byte program can run. The erase is then resumed and continues from the cycle count it had reached. After reset, and after a wake request, busy stays high for a ready delay. This delay is computed in cycles from the clock frequency and a time in microseconds.

Software controls the block through one write-only command byte. Bit 7 is the start bit. Bit 6 is the halt bit, which requests a suspend when 1 and allows a resume when 0. Bits 1:0 select the operation: 00 byte program, 01 page program, 10 sector erase, 11 chip erase. The array is written only by bit-clearing programs (new = old AND data) and by erases that set bytes to 8'hFF.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy is high and reads return 8'hFF for exactly CLK_MHZ*READY_US clock edges. Busy then falls.
- R2: In idle, a command write with bit 7 set and op 11 raises busy on the next cycle and keeps it high for CHIP_CYC cycles. When it falls, every byte reads 8'hFF.
- R3: In idle, with op 00, 01 or 10 selected by an earlier command write, the first CPU write is latched and busy rises on the next cycle. A command write with bit 7 set starts the operation.
- R4: While busy is high, cpu_rdata is 8'hFF, and CPU writes made during execution never reach the array.
- R5: Page program takes writes only within the 16-byte page of the first write; a later write to the same offset replaces the earlier one. Writes to other pages are dropped, and unwritten bytes of the page keep their contents.
- R6: Byte program uses only the first latched write; further writes before start are dropped. The result is the old byte AND the new data.
- R7: Sector erase sets to 8'hFF every byte whose address bits above SECT_AW match the first latched address, and leaves all other bytes unchanged.
- R8: A command write with bit 6 set during a running sector erase drops busy and raises suspended on the next cycle. Reads then return the array contents, and the erase has not yet taken effect.
- R9: In suspend, a command write with bit 7 set and bit 6 clear raises busy and clears suspended. The busy cycles of the erase before and after the pause add up to SECT_CYC.
- R10: In suspend, a CPU write latches a byte program and raises busy while suspended stays high. After start it runs BYTE_CYC cycles, and busy falls with suspended still high.
- R11: A wake request in idle raises busy for exactly CLK_MHZ*READY_US cycles.
- R12: A halt request during a chip erase, page program or byte program is ignored: busy stays high and suspended stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Command byte write strobe |
| reg_wdata | input | 8 | Command byte: [7] start, [6] halt, [1:0] operation |
| cpu_we | input | 1 | CPU write strobe to the array space |
| cpu_addr | input | AW | CPU byte address for reads and writes |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Array read data, 8'hFF while busy |
| wake_req | input | 1 | Power-down exit pulse; restarts the ready delay when idle |
| busy | output | 1 | Operation loading, running or array not ready |
| suspended | output | 1 | A sector erase is paused |

## Verification
If the sequencer reaches a wrong state, busy or suspended shows the wrong value at the next clock edge. cpu_rdata then either returns 8'hFF when it should not, or returns array contents during an operation. A lost or wrongly kept erase count does not show up at once. It appears only when the operation ends, as a difference in the total number of busy cycles. A wrong commit shows up only when the changed bytes are read after busy falls. For this reason the bench compares busy, suspended and read data against its model on every clock, and also counts busy cycles over whole operations.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    S_WAKE, S_IDLE, S_LOAD, S_RUN, S_SUSP, S_SLOAD, S_SRUN
  } fseq_state_e;

  typedef enum logic [1:0] {
    OP_BYTE = 2'b00, OP_PAGE = 2'b01, OP_SECT = 2'b10, OP_CHIP = 2'b11
  } fseq_op_e;

  // Ready delay in clock cycles for a given clock in MHz and time in us.
  function automatic int unsigned ready_cycles(int unsigned mhz, int unsigned us);
    return mhz * us;
  endfunction

  // True when two addresses lie in the same block of 2**bits bytes.
  function automatic logic same_block(int unsigned a, int unsigned b, int unsigned bits);
    return (a >> bits) == (b >> bits);
  endfunction
endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int TW   = 16,
  parameter int INIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= TW'(INIT);
    else if (load)             cnt <= load_val;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == TW'(1));
endmodule

// File: rtl/fseq_array.sv
module fseq_array import fseq_pkg::*; #(
  parameter int AW      = 6,
  parameter int PAGE_AW = 4,
  parameter int SECT_AW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AW-1:0]              rd_addr,
  output logic [7:0]                 rd_data,
  input  logic                       prog,
  input  logic                       er_sect,
  input  logic                       er_chip,
  input  logic [AW-1:0]              base,
  input  logic [(8<<PAGE_AW)-1:0]    pdata,
  input  logic [(1<<PAGE_AW)-1:0]    pmask
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_AW;

  logic [7:0] mem [DEPTH];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (er_chip) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (er_sect) begin
      for (int j = 0; j < DEPTH; j++)
        if (same_block(j, int'(base), SECT_AW)) mem[j] <= 8'hFF;
    end else if (prog) begin
      for (int i = 0; i < PAGE; i++)
        if (pmask[i])
          mem[{base[AW-1:PAGE_AW], PAGE_AW'(i)}] <=
            mem[{base[AW-1:PAGE_AW], PAGE_AW'(i)}] & pdata[i*8 +: 8];
    end
  end
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl import fseq_pkg::*; #(
  parameter int AW        = 6,
  parameter int PAGE_AW   = 4,
  parameter int TW        = 16,
  parameter int READY_CYC = 1000,
  parameter int BYTE_CYC  = 20,
  parameter int PAGE_CYC  = 40,
  parameter int SECT_CYC  = 200,
  parameter int CHIP_CYC  = 300
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [7:0]              reg_wdata,
  input  logic                    cpu_we,
  input  logic [AW-1:0]           cpu_addr,
  input  logic [7:0]              cpu_wdata,
  input  logic                    wake_req,
  output logic                    busy,
  output logic                    suspended,
  output logic                    m_load,
  output logic [TW-1:0]           m_val,
  output logic                    m_run,
  input  logic                    m_done,
  output logic                    a_load,
  output logic [TW-1:0]           a_val,
  output logic                    a_run,
  input  logic                    a_done,
  output logic                    prog,
  output logic                    er_sect,
  output logic                    er_chip,
  output logic [AW-1:0]           base,
  output logic [(8<<PAGE_AW)-1:0] pdata,
  output logic [(1<<PAGE_AW)-1:0] pmask,
  output logic                    erase_run,
  output logic                    resume_ev,
  output logic                    ev_commit
);
  localparam int PAGE = 1 << PAGE_AW;

  fseq_state_e        st;
  fseq_op_e           op_q;
  logic [AW-1:0]      lat_addr, sect_q;
  logic [8*PAGE-1:0]  lat_data;
  logic [PAGE-1:0]    lat_mask;

  logic     go, halt, first_wr, suspend_ev;
  fseq_op_e sel_op;
  logic [PAGE_AW-1:0] off;

  function automatic logic [TW-1:0] op_len(fseq_op_e o);
    case (o)
      OP_BYTE: return TW'(BYTE_CYC);
      OP_PAGE: return TW'(PAGE_CYC);
      OP_SECT: return TW'(SECT_CYC);
      default: return TW'(CHIP_CYC);
    endcase
  endfunction

  assign go       = reg_we && reg_wdata[7];
  assign halt     = reg_wdata[6];
  assign sel_op   = fseq_op_e'(reg_wdata[1:0]);
  assign off      = cpu_addr[PAGE_AW-1:0];
  assign first_wr = cpu_we && op_q != OP_CHIP;

  assign busy      = !(st == S_IDLE || st == S_SUSP);
  assign suspended = (st == S_SUSP) || (st == S_SLOAD) || (st == S_SRUN);

  assign m_run  = (st == S_RUN);
  assign m_load = (st == S_IDLE && go && sel_op == OP_CHIP) || (st == S_LOAD && go);
  assign m_val  = (st == S_IDLE) ? TW'(CHIP_CYC) : op_len(op_q);

  assign a_run  = (st == S_WAKE) || (st == S_SRUN);
  assign a_load = (st == S_IDLE && !reg_we && !first_wr && wake_req) || (st == S_SLOAD && go);
  assign a_val  = (st == S_SLOAD) ? TW'(BYTE_CYC) : TW'(READY_CYC);

  assign erase_run  = (st == S_RUN) && (op_q == OP_SECT);
  assign suspend_ev = erase_run && reg_we && halt && !m_done;
  assign resume_ev  = (st == S_SUSP) && go && !halt;

  assign prog    = (m_run && m_done && (op_q == OP_BYTE || op_q == OP_PAGE)) ||
                   (st == S_SRUN && a_done);
  assign er_sect = m_run && m_done && op_q == OP_SECT;
  assign er_chip = m_run && m_done && op_q == OP_CHIP;
  assign ev_commit = prog || er_sect || er_chip;

  assign base  = er_sect ? sect_q : lat_addr;
  assign pdata = lat_data;
  assign pmask = lat_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_WAKE;
      op_q     <= OP_BYTE;
      lat_addr <= '0;
      sect_q   <= '0;
      lat_data <= '0;
      lat_mask <= '0;
    end else begin
      case (st)
        S_WAKE: if (a_done) st <= S_IDLE;
        S_IDLE: begin
          if (reg_we) begin
            op_q <= sel_op;
            if (go && sel_op == OP_CHIP) st <= S_RUN;
          end else if (first_wr) begin
            lat_addr             <= cpu_addr;
            lat_mask             <= PAGE'(1) << off;
            lat_data[off*8 +: 8] <= cpu_wdata;
            if (op_q == OP_SECT) sect_q <= cpu_addr;
            st <= S_LOAD;
          end else if (wake_req) begin
            st <= S_WAKE;
          end
        end
        S_LOAD: begin
          if (go) st <= S_RUN;
          else if (cpu_we && op_q == OP_PAGE &&
                   same_block(int'(cpu_addr), int'(lat_addr), PAGE_AW)) begin
            lat_mask[off]        <= 1'b1;
            lat_data[off*8 +: 8] <= cpu_wdata;
          end
        end
        S_RUN: begin
          if (m_done)          st <= S_IDLE;
          else if (suspend_ev) st <= S_SUSP;
        end
        S_SUSP: begin
          if (reg_we) begin
            if (go && !halt) st <= S_RUN;
          end else if (cpu_we) begin
            lat_addr             <= cpu_addr;
            lat_mask             <= PAGE'(1) << off;
            lat_data[off*8 +: 8] <= cpu_wdata;
            st <= S_SLOAD;
          end
        end
        S_SLOAD: if (go) st <= S_SRUN;
        S_SRUN:  if (a_done) st <= S_SUSP;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq import fseq_pkg::*; #(
  parameter int AW       = 6,
  parameter int PAGE_AW  = 4,
  parameter int SECT_AW  = 5,
  parameter int TW       = 16,
  parameter int CLK_MHZ  = 100,
  parameter int READY_US = 10,
  parameter int BYTE_CYC = 20,
  parameter int PAGE_CYC = 40,
  parameter int SECT_CYC = 200,
  parameter int CHIP_CYC = 300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic          wake_req,
  output logic          busy,
  output logic          suspended
);
  localparam int READY_CYC = int'(ready_cycles(CLK_MHZ, READY_US));
  localparam int PAGE      = 1 << PAGE_AW;

  logic          m_load, m_run, m_done, a_load, a_run, a_done;
  logic [TW-1:0] m_val, a_val;
  logic          prog, er_sect, er_chip;
  logic [AW-1:0] base;
  logic [8*PAGE-1:0] pdata;
  logic [PAGE-1:0]   pmask;
  logic [7:0]    arr_rd;
  logic          erase_run, resume_ev, ev_commit;

  fseq_ctrl #(
    .AW(AW), .PAGE_AW(PAGE_AW), .TW(TW), .READY_CYC(READY_CYC),
    .BYTE_CYC(BYTE_CYC), .PAGE_CYC(PAGE_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .wake_req(wake_req),
    .busy(busy), .suspended(suspended),
    .m_load(m_load), .m_val(m_val), .m_run(m_run), .m_done(m_done),
    .a_load(a_load), .a_val(a_val), .a_run(a_run), .a_done(a_done),
    .prog(prog), .er_sect(er_sect), .er_chip(er_chip), .base(base),
    .pdata(pdata), .pmask(pmask),
    .erase_run(erase_run), .resume_ev(resume_ev), .ev_commit(ev_commit)
  );

  fseq_timer #(.TW(TW), .INIT(0)) u_op_tmr (
    .clk(clk), .rst_n(rst_n), .load(m_load), .load_val(m_val), .run(m_run), .done(m_done)
  );

  fseq_timer #(.TW(TW), .INIT(READY_CYC)) u_aux_tmr (
    .clk(clk), .rst_n(rst_n), .load(a_load), .load_val(a_val), .run(a_run), .done(a_done)
  );

  fseq_array #(.AW(AW), .PAGE_AW(PAGE_AW), .SECT_AW(SECT_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(cpu_addr), .rd_data(arr_rd),
    .prog(prog), .er_sect(er_sect), .er_chip(er_chip), .base(base),
    .pdata(pdata), .pmask(pmask)
  );

  assign cpu_rdata = busy ? 8'hFF : arr_rd;
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       suspended,
  input logic [7:0] cpu_rdata,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic       erase_run,
  input logic       resume_ev,
  input logic       ev_commit
);
  // R4
  busy_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cpu_rdata == 8'hFF);

  // R4
  commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |-> busy);

  // R8
  suspend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_run && reg_we && reg_wdata[6] && !ev_commit |=> suspended && !busy);

  // R9
  resume_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_ev |=> busy && !suspended);

  // R10
  susp_prog_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && busy |=> suspended);
endmodule

bind flash_seq fseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .suspended(suspended), .cpu_rdata(cpu_rdata),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .erase_run(erase_run),
  .resume_ev(resume_ev), .ev_commit(ev_commit)
);

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  localparam int READY  = 100 * 10;
  localparam int BYTE_C = 20;
  localparam int PAGE_C = 40;
  localparam int SECT_C = 200;
  localparam int CHIP_C = 300;

  logic       clk = 0, rst_n = 0, reg_we = 0, cpu_we = 0, wake_req = 0;
  logic [7:0] reg_wdata = 0, cpu_wdata = 0;
  logic [5:0] cpu_addr = 0;
  wire  [7:0] cpu_rdata;
  wire        busy, suspended;

  always #5 clk = ~clk;

  flash_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .wake_req(wake_req), .busy(busy), .suspended(suspended)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  bit finished = 0, cnt_en = 0;
  int busy_ticks = 0;

  // Reference model: phase 0 warming, 1 idle, 2 collecting, 3 working,
  // 4 paused, 5 collecting while paused, 6 programming while paused.
  int ph, rem, aux, opq, sect, pbase;
  int mm [64];
  int qa[$], qd[$];
  bit mgo, mhalt;
  int msel;

  function automatic bit m_busy();
    return ph == 0 || ph == 2 || ph == 3 || ph == 5 || ph == 6;
  endfunction
  function automatic bit m_susp();
    return ph >= 4;
  endfunction

  task automatic apply_prog();
    int fin[int];
    foreach (qa[k]) fin[qa[k]] = qd[k];
    foreach (fin[a]) mm[a] = mm[a] & fin[a];
    qa.delete(); qd.delete();
  endtask

  task automatic apply_finish();
    if (opq <= 1) apply_prog();
    else if (opq == 2) begin
      for (int a = 0; a < 64; a++) if ((a / 32) == (sect / 32)) mm[a] = 8'hFF;
    end else begin
      for (int a = 0; a < 64; a++) mm[a] = 8'hFF;
    end
  endtask

  always @(posedge clk) begin
    mgo = reg_we && reg_wdata[7];
    mhalt = reg_wdata[6];
    msel = int'(reg_wdata[1:0]);
    if (!rst_n) begin
      ph = 0; aux = READY; rem = 0; opq = 0;
      for (int i = 0; i < 64; i++) mm[i] = 8'hFF;
      qa.delete(); qd.delete();
    end else begin
      case (ph)
        0: if (aux == 1) ph = 1; else aux--;
        1: begin
          if (reg_we) begin
            opq = msel;
            if (mgo && msel == 3) begin rem = CHIP_C; ph = 3; end
          end else if (cpu_we && opq != 3) begin
            qa.delete(); qd.delete();
            qa.push_back(int'(cpu_addr)); qd.push_back(int'(cpu_wdata));
            pbase = int'(cpu_addr); sect = int'(cpu_addr); ph = 2;
          end else if (wake_req) begin
            aux = READY; ph = 0;
          end
        end
        2: begin
          if (mgo) begin
            rem = (opq == 0) ? BYTE_C : (opq == 1) ? PAGE_C : SECT_C;
            ph = 3;
          end else if (cpu_we && opq == 1 && (int'(cpu_addr) / 16) == (pbase / 16)) begin
            qa.push_back(int'(cpu_addr)); qd.push_back(int'(cpu_wdata));
          end
        end
        3: begin
          if (rem == 1) begin apply_finish(); ph = 1; end
          else begin
            rem--;
            if (reg_we && mhalt && opq == 2) ph = 4;
          end
        end
        4: begin
          if (reg_we) begin
            if (mgo && !mhalt) ph = 3;
          end else if (cpu_we) begin
            qa.delete(); qd.delete();
            qa.push_back(int'(cpu_addr)); qd.push_back(int'(cpu_wdata));
            ph = 5;
          end
        end
        5: if (mgo) begin aux = BYTE_C; ph = 6; end
        6: if (aux == 1) begin apply_prog(); ph = 4; end else aux--;
        default: ph = 1;
      endcase
    end
  end

  task automatic tick();
    int exp_rd;
    @(negedge clk);
    exp_rd = m_busy() ? 8'hFF : mm[cpu_addr];
    checks++;
    if (busy !== m_busy() || suspended !== m_susp() || cpu_rdata !== 8'(exp_rd)) begin
      errors++;
      $display("FAIL %s model: busy=%0b susp=%0b rd=%h expected busy=%0b susp=%0b rd=%h",
               tag, busy, suspended, cpu_rdata, m_busy(), m_susp(), 8'(exp_rd));
    end
    if (cnt_en && busy) busy_ticks++;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(int op, bit go, bit hlt);
    reg_we = 1; reg_wdata = {go, hlt, 4'b0, 2'(op)};
    tick();
    reg_we = 0; reg_wdata = 0;
  endtask

  task automatic cpu_wr(int a, int d);
    cpu_we = 1; cpu_addr = 6'(a); cpu_wdata = 8'(d);
    tick();
    cpu_we = 0;
  endtask

  task automatic rd(string req, int a, int exp);
    cpu_addr = 6'(a);
    #1;
    chk(req, int'(cpu_rdata), exp);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    do begin tick(); n++; end while (busy && n < 5000);
  endtask

  task automatic byte_prog(int a, int d);
    int n;
    reg_wr(0, 0, 0); cpu_wr(a, d); reg_wr(0, 1, 0); wait_idle(n);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy in reset", int'(busy), 1);
    chk("R1 read in reset", int'(cpu_rdata), 8'hFF);
    rst_n = 1;
    n = 0;
    do begin tick(); n++; end while (busy && n < 5000);
    chk("R1 ready delay", n, READY);

    // R3 / R6 byte program
    tag = "R3";
    reg_wr(0, 0, 0);
    cpu_wr(5, 8'hA5);
    chk("R3 busy after first write", int'(busy), 1);
    tag = "R6";
    cpu_wr(6, 8'h00);
    reg_wr(0, 1, 0);
    wait_idle(n);
    rd("R6 first byte", 5, 8'hA5);
    rd("R6 second write dropped", 6, 8'hFF);

    tag = "R4";
    reg_wr(0, 0, 0); cpu_wr(5, 8'h3C); reg_wr(0, 1, 0);
    rd("R4 read while busy", 5, 8'hFF);
    cpu_wr(7, 8'h00);
    wait_idle(n);
    rd("R6 and-program", 5, 8'h24);
    rd("R4 write during run dropped", 7, 8'hFF);

    // R5 page program
    tag = "R5";
    reg_wr(1, 0, 0);
    cpu_wr(6'h12, 8'h11); cpu_wr(6'h13, 8'h22); cpu_wr(6'h12, 8'h33); cpu_wr(6'h25, 8'h77);
    reg_wr(1, 1, 0);
    wait_idle(n);
    rd("R5 replaced offset", 6'h12, 8'h33);
    rd("R5 second offset", 6'h13, 8'h22);
    rd("R5 other page dropped", 6'h25, 8'hFF);
    rd("R5 untouched byte", 6'h14, 8'hFF);

    // R7 sector erase
    tag = "R7";
    byte_prog(6'h30, 8'h0F);
    rd("R7 setup", 6'h30, 8'h0F);
    reg_wr(2, 0, 0); cpu_wr(6'h31, 0); reg_wr(2, 1, 0);
    wait_idle(n);
    rd("R7 sector erased", 6'h30, 8'hFF);
    rd("R7 other sector kept", 6'h12, 8'h33);

    // R8 / R10 / R9 suspend, program, resume
    tag = "R8";
    byte_prog(6'h22, 8'h00);
    reg_wr(2, 0, 0); cpu_wr(6'h20, 0);
    busy_ticks = 0; cnt_en = 1;
    reg_wr(2, 1, 0);
    repeat (50) tick();
    reg_wr(2, 0, 1);
    cnt_en = 0;
    chk("R8 busy low in suspend", int'(busy), 0);
    chk("R8 suspended high", int'(suspended), 1);
    rd("R8 erase not applied", 6'h22, 8'h00);

    tag = "R10";
    cpu_wr(5, 8'h20);
    chk("R10 busy during suspend program", int'(busy), 1);
    chk("R10 still suspended", int'(suspended), 1);
    reg_wr(0, 1, 0);
    wait_idle(n);
    chk("R10 back to suspend", int'(suspended), 1);
    chk("R10 busy low", int'(busy), 0);
    rd("R10 programmed", 5, 8'h20);

    tag = "R9";
    cnt_en = 1;
    reg_wr(2, 1, 0);
    chk("R9 busy on resume", int'(busy), 1);
    chk("R9 suspend cleared", int'(suspended), 0);
    wait_idle(n);
    cnt_en = 0;
    chk("R9 total erase cycles", busy_ticks, SECT_C);
    rd("R9 sector erased", 6'h22, 8'hFF);
    rd("R9 other sector kept", 5, 8'h20);

    // R2 chip erase and R12 halt ignored
    tag = "R2";
    busy_ticks = 0; cnt_en = 1;
    reg_wr(3, 1, 0);
    chk("R2 busy after start", int'(busy), 1);
    tag = "R12";
    reg_wr(3, 0, 1);
    chk("R12 busy kept", int'(busy), 1);
    chk("R12 no suspend", int'(suspended), 0);
    wait_idle(n);
    cnt_en = 0;
    chk("R2 chip cycles", busy_ticks, CHIP_C);
    rd("R2 erased a", 5, 8'hFF);
    rd("R2 erased b", 6'h12, 8'hFF);

    tag = "R12";
    reg_wr(1, 0, 0); cpu_wr(6'h01, 8'h5A); reg_wr(1, 1, 0);
    reg_wr(1, 0, 1);
    chk("R12 page halt ignored", int'(suspended), 0);
    wait_idle(n);
    rd("R12 page done", 6'h01, 8'h5A);

    // R11 wake
    tag = "R11";
    busy_ticks = 0; cnt_en = 1;
    wake_req = 1; tick(); wake_req = 0;
    chk("R11 busy on wake", int'(busy), 1);
    wait_idle(n);
    cnt_en = 0;
    chk("R11 wake delay", busy_ticks, READY);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL %s watchdog: actual hung expected done", tag);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule